// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block keeps an in-order five-stage pipeline correct when an instruction in decode reads a register that the load now in execute has not yet fetched from memory. Forwarding cannot help here, because the loaded value only exists one cycle later. The hardware finds the case itself and holds the front of the pipe for one cycle. No no-op padding from the compiler is needed.

While a stall is active, the program counter and the fetch/decode register keep their values. The execute, memory and writeback control fields that enter the decode/execute register are forced to zero, so that register holds a bubble. The register-number fields still pass through unchanged. After one cycle the load has moved past execute and the dependent instruction continues, with its operand then available by forwarding. The stall detector sits in a small test wrapper. The wrapper holds the PC, the fetch/decode register, the decode/execute register with its control fields, and an opcode decoder. A program memory outside the wrapper supplies the fetched word.

Top module: `luh_pipe_top`

## Requirements
- R1: A stall is raised in any cycle where the decode/execute control has its memory-read bit set and that register's Rt field (bits 20:16 of the load) equals the Rs field (bits 25:21) of the instruction in fetch/decode.
- R2: A stall is also raised when the load's Rt equals the Rt field (bits 20:16) of the instruction in fetch/decode.
- R3: There is no stall when the instruction in execute is not a load, even if register numbers match. There is also no stall when a load and its reader are separated by another instruction.
- R4: During a stall `pc_we` is 0 and the PC keeps its value at the next edge. Otherwise the PC advances by 4.
- R5: During a stall `ifid_we` is 0 and the fetch/decode register keeps its instruction, so the dependent instruction sits in decode for two consecutive cycles.
- R6: The edge that ends a stall cycle loads all-zero control into the decode/execute register, while its Rs, Rt and Rd fields are still copied from fetch/decode.
- R7: A stall lasts exactly one cycle. The cycle after a stall has no stall from the same load.
- R8: With `rst_n` low, `bubble` is 0, `pc_we` and `ifid_we` are 1, and the PC, both pipeline registers and the control are zero.
- R9: The control byte is {reg_wr, mem_to_reg, mem_rd, mem_wr, reg_dst, alu_src, alu_op[1:0]}, with the opcode in bits 31:26. Opcode 0x23 (load) gives 0xE4, and 0x2B (store) gives 0x14. Opcode 0x00 with a nonzero word (register op) gives 0x8A. The all-zero word and any other opcode give 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_instr | input | 32 | Instruction word at the current PC |
| pc_q | output | PC_W | Program counter |
| ifid_instr | output | 32 | Instruction held in fetch/decode |
| idex_ctrl | output | 8 | Control byte in decode/execute (R9 layout) |
| idex_rs | output | 5 | Rs field in decode/execute |
| idex_rt | output | 5 | Rt field in decode/execute |
| idex_rd | output | 5 | Rd field in decode/execute |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode write enable |
| bubble | output | 1 | Zero the control entering decode/execute |

## Verification
The assertions check these rules on every cycle:
- any load-use match in the registered state must raise `bubble`, and a non-load in execute must not;
- a dropped enable must freeze the PC and the fetch/decode register;
- every bubble must be followed by zero control, copied register fields and no second bubble.

Only the bench's programs can show other things. One is that whole instruction sequences come out right: a load feeding a second load's base, a load feeding a store's data, and a reader two slots behind a load. Another is the exact number of stalls each program produces. A third is that the decoder gives each opcode the expected control byte.

// File: rtl/luh_pkg.sv
package luh_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int OP_W    = 6;
  localparam int OP_LSB  = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;

  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

  typedef struct packed {
    logic       reg_wr;
    logic       mem_to_reg;
    logic       mem_rd;
    logic       mem_wr;
    logic       reg_dst;
    logic       alu_src;
    logic [1:0] alu_op;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [REG_W-1:0] field_rs(input logic [INSTR_W-1:0] w);
    return w[RS_LSB +: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] field_rt(input logic [INSTR_W-1:0] w);
    return w[RT_LSB +: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] field_rd(input logic [INSTR_W-1:0] w);
    return w[RD_LSB +: REG_W];
  endfunction

  function automatic ctrl_t decode_ctrl(input logic [INSTR_W-1:0] w);
    ctrl_t c;
    c = '0;
    if (w != '0) begin
      unique case (w[OP_LSB +: OP_W])
        OP_LOAD: begin
          c.reg_wr = 1'b1; c.mem_to_reg = 1'b1; c.mem_rd = 1'b1; c.alu_src = 1'b1;
        end
        OP_STORE: begin
          c.mem_wr = 1'b1; c.alu_src = 1'b1;
        end
        OP_REG: begin
          c.reg_wr = 1'b1; c.reg_dst = 1'b1; c.alu_op = 2'b10;
        end
        default: c = '0;
      endcase
    end
    return c;
  endfunction

  function automatic logic reads_loaded(input logic mem_rd,
                                        input logic [REG_W-1:0] load_dst,
                                        input logic [REG_W-1:0] src);
    return mem_rd && (load_dst == src);
  endfunction
endpackage

// File: rtl/luh_decode.sv
module luh_decode
  import luh_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  assign ctrl = decode_ctrl(instr);
endmodule

// File: rtl/luh_hazard_detect.sv
module luh_hazard_detect
  import luh_pkg::*;
#(
  parameter int NSRC = 2
)(
  input  logic                        rst_n,
  input  logic                        ex_mem_rd,
  input  logic [REG_W-1:0]            ex_load_dst,
  input  logic [NSRC-1:0][REG_W-1:0]  id_src,
  output logic                        hazard,
  output logic                        pc_we,
  output logic                        ifid_we,
  output logic                        zero_ctrl
);
  logic [NSRC-1:0] src_hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = reads_loaded(ex_mem_rd, ex_load_dst, id_src[g]);
  end

  assign hazard    = rst_n && (|src_hit);
  assign pc_we     = !hazard;
  assign ifid_we   = !hazard;
  assign zero_ctrl = hazard;
endmodule

// File: rtl/luh_pipe_top.sv
module luh_pipe_top
  import luh_pkg::*;
#(
  parameter int PC_W = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        fetch_instr,
  output logic [PC_W-1:0]    pc_q,
  output logic [31:0]        ifid_instr,
  output logic [7:0]         idex_ctrl,
  output logic [4:0]         idex_rs,
  output logic [4:0]         idex_rt,
  output logic [4:0]         idex_rd,
  output logic               pc_we,
  output logic               ifid_we,
  output logic               bubble
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_W / 8);
  localparam int NSRC = 2;

  logic [PC_W-1:0]           pc_r;
  logic [INSTR_W-1:0]        ifid_r;
  ctrl_t                     idex_ctrl_r;
  logic [REG_W-1:0]          idex_rs_r, idex_rt_r, idex_rd_r;
  ctrl_t                     dec_ctrl;
  ctrl_t                     ctrl_in;
  logic [NSRC-1:0][REG_W-1:0] id_src;
  logic                      hazard, pc_we_w, ifid_we_w, zero_ctrl_w;

  luh_decode u_dec (
    .instr (ifid_r),
    .ctrl  (dec_ctrl)
  );

  assign id_src[0] = field_rs(ifid_r);
  assign id_src[1] = field_rt(ifid_r);

  luh_hazard_detect #(.NSRC(NSRC)) u_haz (
    .rst_n       (rst_n),
    .ex_mem_rd   (idex_ctrl_r.mem_rd),
    .ex_load_dst (idex_rt_r),
    .id_src      (id_src),
    .hazard      (hazard),
    .pc_we       (pc_we_w),
    .ifid_we     (ifid_we_w),
    .zero_ctrl   (zero_ctrl_w)
  );

  assign ctrl_in = zero_ctrl_w ? ctrl_t'('0) : dec_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_r <= '0;
    end else if (pc_we_w) begin
      pc_r <= pc_r + PC_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifid_r <= '0;
    end else if (ifid_we_w) begin
      ifid_r <= fetch_instr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_ctrl_r <= '0;
      idex_rs_r   <= '0;
      idex_rt_r   <= '0;
      idex_rd_r   <= '0;
    end else begin
      idex_ctrl_r <= ctrl_in;
      idex_rs_r   <= field_rs(ifid_r);
      idex_rt_r   <= field_rt(ifid_r);
      idex_rd_r   <= field_rd(ifid_r);
    end
  end

  assign pc_q       = pc_r;
  assign ifid_instr = ifid_r;
  assign idex_ctrl  = idex_ctrl_r;
  assign idex_rs    = idex_rs_r;
  assign idex_rt    = idex_rt_r;
  assign idex_rd    = idex_rd_r;
  assign pc_we      = pc_we_w;
  assign ifid_we    = ifid_we_w;
  assign bubble     = hazard;
endmodule

// File: rtl/luh_chk.sv
module luh_chk #(
  parameter int PC_W = 32
)(
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc_q,
  input logic [31:0]     ifid_instr,
  input logic [7:0]      idex_ctrl,
  input logic [4:0]      idex_rs,
  input logic [4:0]      idex_rt,
  input logic [4:0]      idex_rd,
  input logic            pc_we,
  input logic            ifid_we,
  input logic            bubble
);
  // R1
  rs_match_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_ctrl[5] && idex_rt == ifid_instr[25:21]) |-> bubble);
  // R2
  rt_match_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_ctrl[5] && idex_rt == ifid_instr[20:16]) |-> bubble);
  // R3
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_ctrl[5] |-> !bubble);
  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc_q));
  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> pc_q == $past(pc_q) + PC_W'(4));
  // R5
  ifid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_we |=> $stable(ifid_instr));
  // R6
  bubble_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> idex_ctrl == 8'h00);
  // R6
  bubble_fields_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (idex_rs == $past(ifid_instr[25:21]) && idex_rt == $past(ifid_instr[20:16])
                && idex_rd == $past(ifid_instr[15:11])));
  // R7
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble);
  // R8
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (!bubble && pc_we && ifid_we);
    end
  end
endmodule

bind luh_pipe_top luh_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_q       (pc_q),
  .ifid_instr (ifid_instr),
  .idex_ctrl  (idex_ctrl),
  .idex_rs    (idex_rs),
  .idex_rt    (idex_rt),
  .idex_rd    (idex_rd),
  .pc_we      (pc_we),
  .ifid_we    (ifid_we),
  .bubble     (bubble)
);

// File: tb/tb_luh_pipe_top.sv
module tb_luh_pipe_top;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     fetch_instr;
  logic [PC_W-1:0] pc_q;
  logic [31:0]     ifid_instr;
  logic [7:0]      idex_ctrl;
  logic [4:0]      idex_rs, idex_rt, idex_rd;
  logic            pc_we, ifid_we, bubble;

  always #2.5 clk = ~clk;

  logic [31:0] imem [16];
  assign fetch_instr = imem[pc_q[5:2]];

  luh_pipe_top #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .pc_q(pc_q),
    .ifid_instr(ifid_instr), .idex_ctrl(idex_ctrl), .idex_rs(idex_rs),
    .idex_rt(idex_rt), .idex_rd(idex_rd), .pc_we(pc_we), .ifid_we(ifid_we),
    .bubble(bubble)
  );

  int errors = 0;
  int checks = 0;
  int stall_seen = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_reg(input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 11'h020};
  endfunction
  function automatic logic [31:0] enc_ld(input int base, input int rt, input int off);
    return {6'h23, 5'(base), 5'(rt), 16'(off)};
  endfunction
  function automatic logic [31:0] enc_st(input int base, input int rt, input int off);
    return {6'h2B, 5'(base), 5'(rt), 16'(off)};
  endfunction

  // R9: control byte expected per opcode
  function automatic logic [7:0] exp_ctrl(input logic [31:0] w);
    if (w == 32'h0) return 8'h00;
    case (w[31:26])
      6'h23:   return 8'hE4;
      6'h2B:   return 8'h14;
      6'h00:   return 8'h8A;
      default: return 8'h00;
    endcase
  endfunction

  typedef struct {
    logic [31:0] pc;
    logic [31:0] ifid;
    logic [7:0]  ctrl;
    logic [4:0]  rt;
    logic        stall;
  } item_t;

  item_t sb_q[$];

  logic [31:0] m_pc, m_ifid;
  logic [7:0]  m_ctrl;
  logic [4:0]  m_rt;

  function automatic logic model_stall();
    return m_ctrl[5] && (m_rt == m_ifid[25:21] || m_rt == m_ifid[20:16]);
  endfunction

  // driver: advances the reference one cycle per edge and queues the result
  task automatic drive_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic  st;
      logic [31:0] old_ifid;
      @(posedge clk);
      st = model_stall();
      old_ifid = m_ifid;
      if (!st) begin
        m_ifid = imem[m_pc[5:2]];
        m_pc   = m_pc + 32'd4;
      end
      m_ctrl = st ? 8'h00 : exp_ctrl(old_ifid);
      m_rt   = old_ifid[20:16];
      it.pc = m_pc; it.ifid = m_ifid; it.ctrl = m_ctrl; it.rt = m_rt;
      it.stall = model_stall();
      sb_q.push_back(it);
    end
  endtask

  // monitor: compares queued expectations away from the clock edge
  logic        prev_bub;
  logic [31:0] prev_ifid;
  initial begin
    prev_bub = 1'b0;
    prev_ifid = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_bub = 1'b0;
      end else begin
        if (prev_bub) begin
          // R5: instruction held in decode two cycles
          check(ifid_instr == prev_ifid, "R5", "ifid held", ifid_instr, prev_ifid);
          // R7: only one stall cycle
          check(!bubble, "R7", "second stall", 32'(bubble), 32'd0);
        end
        if (sb_q.size() > 0) begin
          item_t e;
          e = sb_q.pop_front();
          check(pc_q == e.pc, "R4", "pc", pc_q, e.pc);
          check(ifid_instr == e.ifid, "R5", "ifid", ifid_instr, e.ifid);
          check(idex_ctrl == e.ctrl, "R6/R9", "idex ctrl", 32'(idex_ctrl), 32'(e.ctrl));
          check(idex_rt == e.rt, "R6", "idex rt", 32'(idex_rt), 32'(e.rt));
          check(bubble == e.stall, "R1/R2/R3", "bubble", 32'(bubble), 32'(e.stall));
          check(pc_we == !e.stall && ifid_we == !e.stall, "R4", "enables",
                {30'd0, pc_we, ifid_we}, {30'd0, !e.stall, !e.stall});
        end
        if (bubble) stall_seen++;
        prev_bub  = bubble;
        prev_ifid = ifid_instr;
      end
    end
  end

  task automatic run_prog(input string req, input int exp_stalls);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(!bubble && pc_we && ifid_we, "R8", "reset enables",
          {29'd0, bubble, pc_we, ifid_we}, 32'h3);
    check(pc_q == 0 && ifid_instr == 0 && idex_ctrl == 0, "R8", "reset regs",
          pc_q | ifid_instr | 32'(idex_ctrl), 32'd0);
    m_pc = '0; m_ifid = '0; m_ctrl = '0; m_rt = '0;
    sb_q.delete();
    stall_seen = 0;
    rst_n = 1'b1;
    drive_cycles(10);
    @(negedge clk);
    #1;
    check(stall_seen == exp_stalls, req, "stall count", 32'(stall_seen), 32'(exp_stalls));
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) imem[i] = 32'h0;
  endtask

  initial begin
    clear_mem();
    // R1: reader uses loaded reg as Rs
    imem[0] = enc_ld(1, 2, 20); imem[1] = enc_reg(2, 5, 4); imem[2] = enc_reg(2, 6, 8);
    run_prog("R1", 1);
    // R2: reader uses loaded reg as Rt
    clear_mem();
    imem[0] = enc_ld(1, 2, 20); imem[1] = enc_reg(6, 2, 8);
    run_prog("R2", 1);
    // R3: one slot between load and reader
    clear_mem();
    imem[0] = enc_ld(1, 2, 20); imem[1] = enc_reg(7, 9, 10); imem[2] = enc_reg(2, 2, 14);
    run_prog("R3", 0);
    // R3: non-load producer with matching numbers
    clear_mem();
    imem[0] = enc_reg(1, 3, 2); imem[1] = enc_reg(2, 2, 4); imem[2] = enc_reg(9, 2, 5);
    run_prog("R3", 0);
    // R6/R9: load feeds a load base, then a store data
    clear_mem();
    imem[0] = enc_ld(1, 2, 0); imem[1] = enc_ld(2, 3, 8); imem[2] = enc_st(2, 3, 100);
    run_prog("R6", 2);
    // R1: load then unrelated reader
    clear_mem();
    imem[0] = enc_ld(1, 2, 4); imem[1] = enc_reg(3, 4, 5); imem[2] = enc_st(6, 7, 0);
    run_prog("R1", 0);
    // R9: unknown opcode gives zero control
    clear_mem();
    imem[0] = {6'h3F, 5'd2, 5'd2, 16'h0}; imem[1] = enc_reg(2, 2, 3);
    run_prog("R9", 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule